// File: doc/BRIEF.md
# Character LCD Power-On Initialisation Sequencer

This block brings up a character LCD that is wired for a 4-bit data path and then writes a fixed demonstration pattern to it. It never drives the display pins itself. Each transfer goes as a request to a separate nibble bus engine, which handles pin timing and busy polling. A request carries a byte, a flag that marks it as display data rather than a command, and a flag asking the engine to send only the upper nibble as a single strobe. The engine answers each request with a one-cycle completion pulse.

After reset the sequencer works through the start-up routine. It waits a set time, then sends the 0x3 reset nibble three times. The gaps between those nibbles get shorter each time. It then switches the display to 4-bit transfers and sends the configuration commands. After that it fills both lines with incrementing ASCII characters at a slow, readable pace. Every delay is derived from the `CLK_HZ` parameter and rounded up to a whole number of clock cycles. A phase output shows which part of the routine is running. A done flag rises once the routine is over, and the block then stays quiet until the next reset.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_n` is low, `reqStart` and `seqDone` are 0 and `phase` is 0.
- R2: The first three requests carry `reqByte` 0x30 with `reqRawNibble` 1 and `reqIsData` 0. The first request comes at least ceil(`CLK_HZ` x 15 ms) cycles after reset is released. The second comes at least ceil(`CLK_HZ` x 4.1 ms) cycles after the first completion. The third comes at least ceil(`CLK_HZ` x 100 us) cycles after the second completion. Each of these waits is exceeded by no more than 4 cycles.
- R3: The fourth request is the full-byte command 0x20 (`reqRawNibble` 0, `reqIsData` 0). The next request follows at least ceil(`CLK_HZ` x 100 us) cycles after its completion, and no more than 4 cycles beyond that.
- R4: Next come the commands 0x28, 0x0C, 0x06, 0x01 and 0x80, in that order. Each has `reqIsData` 0 and `reqRawNibble` 0 and is issued within 4 cycles of the previous completion.
- R5: After 0x80 the block sends seven data requests (`reqIsData` 1) with the bytes 0x30, 0x31, ... 0x36.
- R6: The block then sends the command 0xC0, followed by seven data requests with the bytes 0x41 through 0x47.
- R7: After each data request completes, the next request, or the rise of `seqDone` after the last character, comes at least ceil(`CLK_HZ` x 400 ms) cycles later and no more than 4 cycles beyond that.
- R8: `reqStart` is high for one cycle per request. `reqByte`, `reqIsData` and `reqRawNibble` hold steady from `reqStart` until `reqDone`. No new `reqStart` appears while a request is outstanding.
- R9: `phase` is 0 during the reset nibbles, 1 from the 0x20 command through 0x80, 2 for the line-one characters, 3 from 0xC0 through the line-two characters, and 4 once finished. It never decreases.
- R10: `seqDone` rises after the pause that follows the final character. It then stays high, and no further requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqStart | output | 1 | One-cycle pulse that issues a request to the nibble engine |
| reqByte | output | 8 | Byte to transfer (upper nibble only when raw) |
| reqIsData | output | 1 | 1 = display data, 0 = command |
| reqRawNibble | output | 1 | 1 = send only the upper nibble of `reqByte` |
| reqDone | input | 1 | One-cycle completion pulse from the engine |
| phase | output | 3 | Current phase code (0 to 4, see R9) |
| seqDone | output | 1 | High once the routine has finished |

## Verification
The assertions assume the engine pulses `reqDone` only while a request is outstanding, never in the same cycle as `reqStart`, and for exactly one cycle. The bench models the engine this way. It answers each request after a random latency of 1 to 4 cycles drawn from a seeded `$urandom`, drives the completion for a single cycle, and never replies without a request pending. The bench uses a non-round clock frequency so that every delay must be rounded up.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int STEP_W         = 4;
  localparam int CHARS_PER_LINE = 7;
  localparam int STEP_CFG_FIRST = 4;   // first step reported as configuration
  localparam int STEP_LINE1     = 10;
  localparam int STEP_LINE2     = 11;

  typedef enum logic [2:0] {OP_NONE, OP_RAW, OP_CMD, OP_DATA, OP_END} opKindT;
  typedef enum logic [2:0] {W_NONE, W_POWER, W_SECOND, W_SHORT, W_CHAR} waitSelT;
  typedef enum logic [2:0] {
    PH_RESET = 3'd0, PH_CONFIG = 3'd1, PH_LINE1 = 3'd2, PH_LINE2 = 3'd3, PH_DONE = 3'd4
  } phaseT;

  // One script step: an optional transfer followed by an optional wait.
  typedef struct packed {
    opKindT     op;
    logic [7:0] code;     // command byte, or first character of a data run
    waitSelT    waitSel;
  } stepT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       loadTimer;
    waitSelT    waitSel;
    logic       charLoad;
    logic [7:0] charStart;
    logic       charInc;
  } strobeT;

  function automatic stepT getStep(input logic [STEP_W-1:0] idx);
    stepT s;
    case (idx)
      4'd0:    s = '{OP_NONE, 8'h00, W_POWER};
      4'd1:    s = '{OP_RAW,  8'h30, W_SECOND};
      4'd2:    s = '{OP_RAW,  8'h30, W_SHORT};
      4'd3:    s = '{OP_RAW,  8'h30, W_NONE};
      4'd4:    s = '{OP_CMD,  8'h20, W_SHORT};
      4'd5:    s = '{OP_CMD,  8'h28, W_NONE};
      4'd6:    s = '{OP_CMD,  8'h0C, W_NONE};
      4'd7:    s = '{OP_CMD,  8'h06, W_NONE};
      4'd8:    s = '{OP_CMD,  8'h01, W_NONE};
      4'd9:    s = '{OP_CMD,  8'h80, W_NONE};
      4'd10:   s = '{OP_DATA, 8'h30, W_CHAR};
      4'd11:   s = '{OP_CMD,  8'hC0, W_NONE};
      4'd12:   s = '{OP_DATA, 8'h41, W_CHAR};
      default: s = '{OP_END,  8'h00, W_NONE};
    endcase
    return s;
  endfunction

  // Whole clock cycles covering a time in microseconds, rounded up, at least 1.
  function automatic int cyclesFor(input longint hz, input longint us);
    longint c;
    c = (hz * us + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/lcdseq_datapath.sv
module lcdseq_datapath
  import lcdseq_pkg::*;
#(
  parameter int CNT_POWER  = 750000,
  parameter int CNT_SECOND = 205000,
  parameter int CNT_SHORT  = 5000,
  parameter int CNT_CHAR   = 20000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  strobeT     stb,
  output logic       timerLast,
  output logic [7:0] charCode,
  output logic       charLast
);

  localparam int CNT_MAX_A = (CNT_POWER > CNT_SECOND) ? CNT_POWER : CNT_SECOND;
  localparam int CNT_MAX_B = (CNT_SHORT > CNT_CHAR) ? CNT_SHORT : CNT_CHAR;
  localparam int CNT_MAX   = (CNT_MAX_A > CNT_MAX_B) ? CNT_MAX_A : CNT_MAX_B;
  localparam int TW        = $clog2(CNT_MAX + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] loadVal;
  logic [7:0]    lastCode;

  always_comb begin
    case (stb.waitSel)
      W_POWER:  loadVal = TW'(CNT_POWER);
      W_SECOND: loadVal = TW'(CNT_SECOND);
      W_SHORT:  loadVal = TW'(CNT_SHORT);
      W_CHAR:   loadVal = TW'(CNT_CHAR);
      default:  loadVal = TW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (stb.loadTimer) begin
      timer <= loadVal;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerLast = (timer == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      charCode <= '0;
      lastCode <= '0;
    end else if (stb.charLoad) begin
      charCode <= stb.charStart;
      lastCode <= stb.charStart + 8'(CHARS_PER_LINE - 1);
    end else if (stb.charInc) begin
      charCode <= charCode + 1'b1;
    end
  end

  assign charLast = (charCode == lastCode);

endmodule

// File: rtl/lcdseq_control.sv
module lcdseq_control
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqDone,
  input  logic       timerLast,
  input  logic [7:0] charCode,
  input  logic       charLast,
  output strobeT     stb,
  output logic       reqStart,
  output logic [7:0] reqByte,
  output logic       reqIsData,
  output logic       reqRawNibble,
  output logic [2:0] phase,
  output logic       seqDone
);

  typedef enum logic [2:0] {ST_STEP, ST_ISSUE, ST_BUSY, ST_DELAY, ST_IDLE} stateT;

  stateT             state, nxtState;
  logic [STEP_W-1:0] stepIdx, nxtIdx;
  stepT              cur, nxtStep;
  logic              advance;
  phaseT             phaseNow;

  assign cur     = getStep(stepIdx);
  assign nxtStep = getStep(stepIdx + 1'b1);

  always_comb begin
    stb      = '0;
    nxtState = state;
    nxtIdx   = stepIdx;
    advance  = 1'b0;
    case (state)
      ST_STEP: begin
        if (cur.op == OP_END) begin
          nxtState = ST_IDLE;
        end else if (cur.op == OP_NONE) begin
          if (cur.waitSel != W_NONE) begin
            stb.loadTimer = 1'b1;
            stb.waitSel   = cur.waitSel;
            nxtState      = ST_DELAY;
          end else begin
            advance = 1'b1;
          end
        end else begin
          nxtState = ST_ISSUE;
        end
      end
      ST_ISSUE: nxtState = ST_BUSY;
      ST_BUSY: begin
        if (reqDone) begin
          if (cur.waitSel != W_NONE) begin
            stb.loadTimer = 1'b1;
            stb.waitSel   = cur.waitSel;
            nxtState      = ST_DELAY;
          end else begin
            advance = 1'b1;
          end
        end
      end
      ST_DELAY: if (timerLast) advance = 1'b1;
      default:  nxtState = ST_IDLE;
    endcase

    if (advance) begin
      nxtState = ST_STEP;
      if (cur.op == OP_DATA && !charLast) begin
        stb.charInc = 1'b1;
      end else begin
        nxtIdx = stepIdx + 1'b1;
        if (nxtStep.op == OP_DATA) begin
          stb.charLoad  = 1'b1;
          stb.charStart = nxtStep.code;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_STEP;
      stepIdx <= '0;
    end else begin
      state   <= nxtState;
      stepIdx <= nxtIdx;
    end
  end

  always_comb begin
    if (state == ST_IDLE)                          phaseNow = PH_DONE;
    else if (stepIdx < STEP_W'(STEP_CFG_FIRST))    phaseNow = PH_RESET;
    else if (stepIdx < STEP_W'(STEP_LINE1))        phaseNow = PH_CONFIG;
    else if (stepIdx < STEP_W'(STEP_LINE2))        phaseNow = PH_LINE1;
    else                                           phaseNow = PH_LINE2;
  end

  assign phase        = phaseNow;
  assign seqDone      = (state == ST_IDLE);
  assign reqStart     = (state == ST_ISSUE);
  assign reqIsData    = (cur.op == OP_DATA);
  assign reqRawNibble = (cur.op == OP_RAW);
  assign reqByte      = (cur.op == OP_DATA) ? charCode : cur.code;

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcdseq_pkg::*;
#(
  parameter longint CLK_HZ = 50000000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       reqStart,
  output logic [7:0] reqByte,
  output logic       reqIsData,
  output logic       reqRawNibble,
  input  logic       reqDone,
  output logic [2:0] phase,
  output logic       seqDone
);

  localparam int CNT_POWER  = cyclesFor(CLK_HZ, 15000);
  localparam int CNT_SECOND = cyclesFor(CLK_HZ, 4100);
  localparam int CNT_SHORT  = cyclesFor(CLK_HZ, 100);
  localparam int CNT_CHAR   = cyclesFor(CLK_HZ, 400000);

  strobeT     stb;
  logic       timerLast;
  logic [7:0] charCode;
  logic       charLast;

  lcdseq_control u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqDone      (reqDone),
    .timerLast    (timerLast),
    .charCode     (charCode),
    .charLast     (charLast),
    .stb          (stb),
    .reqStart     (reqStart),
    .reqByte      (reqByte),
    .reqIsData    (reqIsData),
    .reqRawNibble (reqRawNibble),
    .phase        (phase),
    .seqDone      (seqDone)
  );

  lcdseq_datapath #(
    .CNT_POWER  (CNT_POWER),
    .CNT_SECOND (CNT_SECOND),
    .CNT_SHORT  (CNT_SHORT),
    .CNT_CHAR   (CNT_CHAR)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .timerLast (timerLast),
    .charCode  (charCode),
    .charLast  (charLast)
  );

endmodule

// File: rtl/lcdseq_checker.sv
module lcdseq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reqStart,
  input logic [7:0] reqByte,
  input logic       reqIsData,
  input logic       reqRawNibble,
  input logic       reqDone,
  input logic [2:0] phase,
  input logic       seqDone
);

  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= 1'b0;
    else if (reqStart) pending <= 1'b1;
    else if (reqDone)  pending <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reqStart |=> !reqStart);  // R8

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((reqStart || pending) && !reqDone) |=> $stable({reqByte, reqIsData, reqRawNibble}));  // R8

  AST_NO_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !reqStart);  // R8

  AST_PHASE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    phase >= $past(phase));  // R9

  AST_DONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |-> (phase == 3'd4));  // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |=> seqDone);  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    seqDone |-> !reqStart);  // R10

  AST_RAW_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reqStart |-> !(reqRawNibble && reqIsData));  // R2

endmodule

bind lcd_init_seq lcdseq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reqStart     (reqStart),
  .reqByte      (reqByte),
  .reqIsData    (reqIsData),
  .reqRawNibble (reqRawNibble),
  .reqDone      (reqDone),
  .phase        (phase),
  .seqDone      (seqDone)
);

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;

  localparam longint HZ       = 12345;
  localparam int     N_REQ    = 24;
  localparam int     WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqStart;
  logic [7:0] reqByte;
  logic       reqIsData;
  logic       reqRawNibble;
  logic       reqDone = 1'b0;
  logic [2:0] phase;
  logic       seqDone;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_init_seq #(.CLK_HZ(HZ)) u_lcd_init_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqStart     (reqStart),
    .reqByte      (reqByte),
    .reqIsData    (reqIsData),
    .reqRawNibble (reqRawNibble),
    .reqDone      (reqDone),
    .phase        (phase),
    .seqDone      (seqDone)
  );

  function automatic int waitCycles(input longint us);
    longint c;
    c = (HZ * us + 999999) / 1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic logic [7:0] expByte(input int i);
    case (i)
      0, 1, 2: return 8'h30;
      3: return 8'h20;
      4: return 8'h28;
      5: return 8'h0C;
      6: return 8'h06;
      7: return 8'h01;
      8: return 8'h80;
      16: return 8'hC0;
      default: return (i < 16) ? 8'(8'h30 + i - 9) : 8'(8'h41 + i - 17);
    endcase
  endfunction

  function automatic logic expData(input int i);
    return (i >= 9 && i <= 15) || (i >= 17);
  endfunction

  function automatic logic expRaw(input int i);
    return i < 3;
  endfunction

  function automatic logic [2:0] expPhase(input int i);
    if (i < 3)  return 3'd0;
    if (i < 9)  return 3'd1;
    if (i < 16) return 3'd2;
    return 3'd3;
  endfunction

  function automatic int minGap(input int i);
    if (i == 0) return waitCycles(15000);
    if (i == 1) return waitCycles(4100);
    if (i == 2 || i == 4) return waitCycles(100);
    if ((i >= 10 && i <= 16) || i >= 18) return waitCycles(400000);
    return 0;
  endfunction

  function automatic string reqTag(input int i);
    if (i < 3)  return "R2";
    if (i == 3) return "R3";
    if (i < 9)  return "R4";
    if (i < 16) return "R5";
    return "R6";
  endfunction

  function automatic string gapTag(input int i);
    if (i < 3)  return "R2";
    if (i == 4) return "R3";
    if (i > 9 && i != 17 && i >= 10) return "R7";
    return "R4";
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    int lastRef;
    int idx;
    int g;
    int lat;
    logic timedOut;
    void'($urandom(32'd20250611));
    timedOut = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(reqStart == 1'b0, "R1", "reqStart in reset", int'(reqStart), 0);
    check(seqDone == 1'b0, "R1", "seqDone in reset", int'(seqDone), 0);
    check(phase == 3'd0, "R1", "phase in reset", int'(phase), 0);

    rst_n = 1'b1;
    lastRef = cyc;
    idx = 0;
    while (idx < N_REQ && !timedOut) begin
      @(negedge clk);
      if (cyc > WD_LIMIT) begin
        timedOut = 1'b1;
      end else if (reqStart) begin
        g = cyc - lastRef;
        check(reqByte == expByte(idx), reqTag(idx), "byte", int'(reqByte), int'(expByte(idx)));
        check(reqIsData == expData(idx), reqTag(idx), "isData", int'(reqIsData), int'(expData(idx)));
        check(reqRawNibble == expRaw(idx), reqTag(idx), "raw", int'(reqRawNibble), int'(expRaw(idx)));
        check(phase == expPhase(idx), "R9", "phase at request", int'(phase), int'(expPhase(idx)));
        check(g >= minGap(idx) && g <= minGap(idx) + 4, gapTag(idx), "gap", g, minGap(idx));
        // engine model: random latency, directed extremes on the first and last
        if (idx == 0) lat = 1;
        else if (idx == N_REQ - 1) lat = 4;
        else lat = $urandom_range(1, 4);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          check(reqStart == 1'b0, "R8", "start while pending", int'(reqStart), 0);
        end
        reqDone = 1'b1;
        lastRef = cyc;
        @(negedge clk);
        reqDone = 1'b0;
        idx++;
      end
    end

    // R7 / R10: pause after last character then done
    while (!seqDone && !timedOut) begin
      @(negedge clk);
      if (cyc > WD_LIMIT) timedOut = 1'b1;
      check(reqStart == 1'b0, "R10", "extra request", int'(reqStart), 0);
    end
    if (!timedOut) begin
      g = cyc - lastRef;
      check(g >= waitCycles(400000) && g <= waitCycles(400000) + 4, "R7", "final pause",
            g, waitCycles(400000));
      check(phase == 3'd4, "R9", "phase done", int'(phase), 4);
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (reqStart || !seqDone) begin
          check(1'b0, "R10", "idle not quiet", int'({reqStart, seqDone}), 1);
          break;
        end
      end
      check(seqDone == 1'b1, "R10", "seqDone held", int'(seqDone), 1);
    end else begin
      check(1'b0, "R10", "watchdog expired", idx, N_REQ);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule